// File: doc/BRIEF.md
# Stochastic Synaptic Event Expander

This block sits between a synapse routing table and an array of neurons. It accepts one postsynaptic record at a time. A record holds a destination address, an amplitude (weight), a repeat count, a send probability, a reversal-potential code and a broadcast flag. The block turns that record into a train of drive events.

The strength a downstream neuron sees is the amplitude, multiplied by the number of repetitions, multiplied by the chance that each repetition is actually sent. For each repetition the block draws one value from an internal 16-bit linear feedback shift register. It compares the low bits of that value with the probability field. It emits an event only when the comparison allows it. Each emitted event carries the destination, the amplitude and the 8-bit reversal-potential code that drives the analog converter.

A broadcast record reaches a whole group of cells with one event. This serves, for example, for global leak pulses.

The controller is a four-state machine:
- `ST_IDLE` accepts a record. It goes to `ST_BCAST` for a broadcast, to `ST_DRAW` for a repeat count above zero, and stays in `ST_IDLE` for a count of zero.
- `ST_DRAW` makes one random draw and steps the register. It goes to `ST_SEND` when the draw passes. Otherwise it goes back to `ST_DRAW` if repetitions remain, or to `ST_IDLE` after the last one.
- `ST_SEND` holds an event until the consumer takes it. It then goes to `ST_DRAW`, or to `ST_IDLE` after the last repetition.
- `ST_BCAST` holds the single broadcast event until the consumer takes it, then returns to `ST_IDLE`.

Top module: `syn_event_expander`

## Requirements
- R1: After reset, `rec_ready` is 1 and `ev_valid` is 0.
- R2: A non-broadcast record with repeat count N and probability 15 produces exactly N events. Each event carries the record's destination, weight and reversal-potential code, with `ev_bcast` at 0.
- R3: Each repetition sends an event if and only if the probability is 15, or the low 4 bits of the current register value are strictly less than the probability. A probability of 0 therefore never sends.
- R4: The register steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It steps exactly once per repetition, whether or not that repetition sends, and at no other time. The first repetition after a seed load uses the seed itself.
- R5: A non-broadcast record with repeat count 0 is consumed with no event, and `rec_ready` stays 1.
- R6: A pulse on `seed_load` loads `seed_value` into the register. A seed of 0 is replaced by 0x0001. The reset value is 0xACE1.
- R7: After a record with work is accepted, `rec_ready` is 0 until the cycle after the last repetition is handled. `rec_ready` is never 1 while `ev_valid` is 1.
- R8: A broadcast record (`rec_bcast`=1) produces exactly one event with `ev_bcast`=1, whatever its repeat count and probability, and leaves the register unchanged.
- R9: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid` and all event fields hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load the random register from `seed_value` |
| seed_value | input | 16 | Seed value; 0 is mapped to 1 |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Block can take a record |
| rec_dest | input | 12 | Destination neuron address |
| rec_weight | input | 4 | Per-event amplitude |
| rec_repeat | input | 4 | Repetitions per record |
| rec_prob | input | 4 | Send probability in sixteenths; 15 means always send |
| rec_erev | input | 8 | Reversal-potential code |
| rec_bcast | input | 1 | Broadcast record |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_dest | output | 12 | Event destination |
| ev_weight | output | 4 | Event amplitude |
| ev_erev | output | 8 | Reversal-potential code for the converter |
| ev_bcast | output | 1 | Event is a broadcast |

## Verification
Every draw changes the register. So a register that steps too often or too rarely, even by one step, changes the set of repetitions that pass. The damage shows up in the event count of the same record or of the next partial-probability record. A wrong remaining-repetition count shows in the event total, and in the cycle when `rec_ready` comes back. A stuck or early return to idle shows as `rec_ready` rising while an event is still owed. Field capture faults show on the first emitted event, and stall faults show on the first cycle that `ev_ready` is held low.

// File: rtl/sxp_pkg.sv
package sxp_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_RESET = 16'hACE1;
    localparam logic [LFSR_W-1:0] LFSR_ZERO_SUB = 16'h0001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAW  = 2'd1,
        ST_SEND  = 2'd2,
        ST_BCAST = 2'd3
    } sxp_state_e;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/sxp_lfsr.sv
module sxp_lfsr
    import sxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] value
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LFSR_RESET;
        end else if (load) begin
            state_q <= (seed == '0) ? LFSR_ZERO_SUB : seed;
        end else if (step) begin
            state_q <= lfsr_next(state_q);
        end
    end

    assign value = state_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R6
    AST_LFSR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(state_q)); // R4
endmodule

// File: rtl/sxp_gate.sv
module sxp_gate #(
    parameter int PROB_W = 4,
    parameter int RND_W  = 16
) (
    input  logic [RND_W-1:0]  rnd,
    input  logic [PROB_W-1:0] prob,
    output logic              pass
);
    localparam logic [PROB_W-1:0] PROB_ALWAYS = {PROB_W{1'b1}};

    always_comb begin
        if (prob == PROB_ALWAYS) pass = 1'b1;
        else                     pass = (rnd[PROB_W-1:0] < prob);
    end
endmodule

// File: rtl/sxp_ctrl.sv
module sxp_ctrl
    import sxp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    input  logic [CNT_W-1:0] rec_repeat,
    input  logic             rec_bcast,
    input  logic             pass,
    input  logic             ev_ready,
    output logic             rec_ready,
    output logic             accept,
    output logic             step,
    output logic             ev_valid,
    output logic             ev_bcast
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    sxp_state_e       state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rec_valid) begin
                    if (rec_bcast) begin
                        state_d = ST_BCAST;
                    end else if (rec_repeat != '0) begin
                        state_d = ST_DRAW;
                        rem_d   = rec_repeat;
                    end
                end
            end
            ST_DRAW: begin
                if (pass) begin
                    state_d = ST_SEND;
                end else if (rem_q == ONE) begin
                    state_d = ST_IDLE;
                    rem_d   = '0;
                end else begin
                    rem_d = rem_q - ONE;
                end
            end
            ST_SEND: begin
                if (ev_ready) begin
                    rem_d   = rem_q - ONE;
                    state_d = (rem_q == ONE) ? ST_IDLE : ST_DRAW;
                end
            end
            ST_BCAST: begin
                if (ev_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rec_ready = (state_q == ST_IDLE);
        accept    = rec_ready && rec_valid;
        step      = (state_q == ST_DRAW);
        ev_valid  = (state_q == ST_SEND) || (state_q == ST_BCAST);
        ev_bcast  = (state_q == ST_BCAST);
    end

    AST_REP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAW || state_q == ST_SEND) |-> rem_q != '0); // R2
    AST_SEND_AFTER_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_SEND) |-> $past(state_q) == ST_DRAW); // R3
endmodule

// File: rtl/syn_event_expander.sv
module syn_event_expander
    import sxp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WT_W   = 4,
    parameter int CNT_W  = 4,
    parameter int PROB_W = 4,
    parameter int EREV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed_value,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [ADDR_W-1:0] rec_dest,
    input  logic [WT_W-1:0]   rec_weight,
    input  logic [CNT_W-1:0]  rec_repeat,
    input  logic [PROB_W-1:0] rec_prob,
    input  logic [EREV_W-1:0] rec_erev,
    input  logic              rec_bcast,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [ADDR_W-1:0] ev_dest,
    output logic [WT_W-1:0]   ev_weight,
    output logic [EREV_W-1:0] ev_erev,
    output logic              ev_bcast
);
    logic [ADDR_W-1:0] dest_q;
    logic [WT_W-1:0]   weight_q;
    logic [PROB_W-1:0] prob_q;
    logic [EREV_W-1:0] erev_q;
    logic [LFSR_W-1:0] rnd;
    logic              accept, step, pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q   <= '0;
            weight_q <= '0;
            prob_q   <= '0;
            erev_q   <= '0;
        end else if (accept) begin
            dest_q   <= rec_dest;
            weight_q <= rec_weight;
            prob_q   <= rec_prob;
            erev_q   <= rec_erev;
        end
    end

    sxp_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed  (seed_value),
        .step  (step),
        .value (rnd)
    );

    sxp_gate #(.PROB_W(PROB_W), .RND_W(LFSR_W)) u_gate (
        .rnd  (rnd),
        .prob (prob_q),
        .pass (pass)
    );

    sxp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_valid  (rec_valid),
        .rec_repeat (rec_repeat),
        .rec_bcast  (rec_bcast),
        .pass       (pass),
        .ev_ready   (ev_ready),
        .rec_ready  (rec_ready),
        .accept     (accept),
        .step       (step),
        .ev_valid   (ev_valid),
        .ev_bcast   (ev_bcast)
    );

    assign ev_dest   = dest_q;
    assign ev_weight = weight_q;
    assign ev_erev   = erev_q;

    AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_dest) && $stable(ev_weight)
                                     && $stable(ev_erev) && $stable(ev_bcast))); // R9
    AST_NO_READY_WHILE_EV: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !rec_ready); // R7
    AST_PROB_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_bcast) |-> prob_q != '0); // R3
    AST_BCAST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bcast |-> !step); // R8
endmodule

// File: tb/tb_syn_event_expander.sv
module tb_syn_event_expander;
    import sxp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_value = '0;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [11:0] rec_dest = '0;
    logic [3:0]  rec_weight = '0;
    logic [3:0]  rec_repeat = '0;
    logic [3:0]  rec_prob = '0;
    logic [7:0]  rec_erev = '0;
    logic        rec_bcast = 1'b0;
    logic        ev_valid;
    logic        ev_ready = 1'b1;
    logic [11:0] ev_dest;
    logic [3:0]  ev_weight;
    logic [7:0]  ev_erev;
    logic        ev_bcast;

    int vectors = 0;
    int miscompares = 0;
    logic [15:0] model = 16'hACE1;

    always #5 clk = ~clk;

    syn_event_expander dut (.*);

    function automatic logic [15:0] step_model(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_seed(input logic [15:0] s);
        @(negedge clk);
        seed_load = 1'b1;
        seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        model = (s == 16'h0) ? 16'h0001 : s;
    endtask

    // Drive one record, collect events, compare against the model.
    task automatic run_record(input string req, input logic [11:0] d, input logic [3:0] w,
                              input logic [3:0] rep, input logic [3:0] p, input logic [7:0] e,
                              input logic b, input bit bp);
        int exp_n = 0;
        int got_n = 0;
        int cyc = 0;
        logic prev_stall = 1'b0;
        logic [11:0] pd = '0;
        logic [3:0]  pw = '0;
        logic [7:0]  pe = '0;
        if (b) exp_n = 1;
        else begin
            for (int i = 0; i < int'(rep); i++) begin
                if (p == 4'hF || model[3:0] < p) exp_n++;
                model = step_model(model);
            end
        end
        @(negedge clk);
        rec_valid = 1'b1; rec_dest = d; rec_weight = w; rec_repeat = rep;
        rec_prob = p; rec_erev = e; rec_bcast = b;
        @(negedge clk);
        rec_valid = 1'b0;
        if (!b && rep == 4'd0) begin
            check("R5", rec_ready, 1'b1, "ready after zero-repeat record");
            check("R5", ev_valid, 1'b0, "no event for zero-repeat record");
            return;
        end
        check("R7", rec_ready, 1'b0, "ready low after accept");
        while (!rec_ready && cyc < 200) begin
            ev_ready = bp ? (cyc % 3 == 2) : 1'b1;
            #1;
            if (prev_stall) begin
                check("R9", ev_valid, 1'b1, "valid held under stall");
                check("R9", {ev_dest, ev_weight, ev_erev}, {pd, pw, pe}, "fields held under stall");
            end
            if (ev_valid) begin
                check(req, {ev_dest, ev_weight, ev_erev}, {d, w, e}, "event fields");
                check(b ? "R8" : "R2", ev_bcast, b, "broadcast flag");
                if (ev_ready) got_n++;
            end
            prev_stall = ev_valid && !ev_ready;
            pd = ev_dest; pw = ev_weight; pe = ev_erev;
            @(negedge clk);
            cyc++;
        end
        ev_ready = 1'b1;
        check(req, got_n, exp_n, "event count");
        check("R7", ev_valid, 1'b0, "no event once ready returns");
    endtask

    task automatic t_reset();
        #1;
        check("R1", rec_ready, 1'b1, "ready after reset");
        check("R1", ev_valid, 1'b0, "valid after reset");
    endtask

    task automatic t_full_prob();
        load_seed(16'h1234);
        run_record("R2", 12'h0A5, 4'h7, 4'd5, 4'hF, 8'hA0, 1'b0, 1'b0);
        run_record("R2", 12'hFFF, 4'hF, 4'd15, 4'hF, 8'h01, 1'b0, 1'b0);
    endtask

    task automatic t_zero_prob();
        run_record("R3", 12'h010, 4'h3, 4'd12, 4'h0, 8'h55, 1'b0, 1'b0);
    endtask

    task automatic t_partial_prob();
        load_seed(16'hBEEF);
        run_record("R3", 12'h123, 4'h2, 4'd15, 4'h8, 8'h80, 1'b0, 1'b0);
        run_record("R4", 12'h124, 4'h4, 4'd15, 4'h3, 8'h40, 1'b0, 1'b0);
        run_record("R4", 12'h125, 4'h6, 4'd15, 4'hE, 8'hC0, 1'b0, 1'b0);
        run_record("R3", 12'h126, 4'h1, 4'd9, 4'h1, 8'h11, 1'b0, 1'b0);
    endtask

    task automatic t_zero_repeat();
        run_record("R5", 12'h200, 4'h5, 4'd0, 4'hF, 8'h22, 1'b0, 1'b0);
        run_record("R4", 12'h201, 4'h5, 4'd13, 4'h7, 8'h23, 1'b0, 1'b0);
    endtask

    task automatic t_bcast();
        run_record("R8", 12'hF00, 4'h9, 4'd6, 4'h0, 8'h99, 1'b1, 1'b1);
        run_record("R8", 12'h300, 4'h2, 4'd15, 4'h9, 8'h33, 1'b0, 1'b0);
    endtask

    task automatic t_seed_zero();
        load_seed(16'h0000);
        run_record("R6", 12'h400, 4'h8, 4'd15, 4'h5, 8'h44, 1'b0, 1'b0);
        run_record("R6", 12'h401, 4'h8, 4'd15, 4'hA, 8'h45, 1'b0, 1'b0);
    endtask

    task automatic t_backpressure();
        load_seed(16'h7A3C);
        run_record("R9", 12'h555, 4'hC, 4'd10, 4'hF, 8'h5A, 1'b0, 1'b1);
        run_record("R9", 12'h556, 4'hD, 4'd14, 4'h9, 8'h5B, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_record("R4", 12'h0AA, 4'h1, 4'd15, 4'h6, 8'h0F, 1'b0, 1'b0);
        t_full_prob();
        t_zero_prob();
        t_partial_prob();
        t_zero_repeat();
        t_bcast();
        t_seed_zero();
        t_backpressure();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule